// File: doc/BRIEF.md
# Upset-Detecting Parallel Shift-Register Harness

This block is a self-checking structure for measuring single-event upset rates of a programmable device under irradiation. A single toggling flip-flop produces an alternating 0/1 stream that enters many identical long shift-register chains at once. All chains advance one stage per clock. Because every chain receives the same bit, their outputs must agree on every cycle. A bit that flips inside any stage leaves the chain later as a value that disagrees with the others.

On each clock, a vote over all chain outputs picks the reference value. Every chain whose output differs from that reference raises its own mismatch flag for one cycle. A saturating counter adds up the number of disagreeing chains, and a sticky error bit records that at least one upset has been seen. Software-free operation is intended: the harness needs only the external test clock, a reset and a clear input. No golden sequence is stored anywhere.

Top module: `seu_chain_harness`

## Requirements
- R1: While rst_ni is low, and right after it rises before any clock edge, mismatch_o is all zero, upset_cnt_o is 0 and error_o is 0.
- R2: With no upset present, all chains carry the same alternating sequence, and after the fill window mismatch_o stays all zero and upset_cnt_o does not change.
- R3: During the first DEPTH rising edges after reset release, mismatch_o stays zero and nothing is counted or made sticky, even if chain outputs disagree.
- R4: From edge DEPTH+1 onward, on each rising edge, mismatch_o bit k (bit k belongs to chain k) is loaded with 1 exactly when chain k's output differed from the reference value just before that edge. It returns to 0 at the next edge if the disagreement has gone.
- R5: The reference is 1 only when strictly more than N_CHAINS/2 chain outputs are 1; with an even split the reference is 0.
- R6: When enabled and clear_i is low, upset_cnt_o increases on each edge by the number of chains that mismatch on that edge.
- R7: upset_cnt_o saturates at 2^CNT_W-1 and stays there while upsets continue.
- R8: error_o is set on any edge where at least one chain mismatches. It stays set until clear_i is sampled high.
- R9: An edge with clear_i high sets upset_cnt_o to 0 and error_o to 0. Mismatches occurring on that edge are not counted, but mismatch_o still reports them.
- R10: A bit that is corrupted on entry to one chain shows up at that chain's output exactly DEPTH edges later, and is flagged for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | External test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the upset counter and error bit |
| mismatch_o | output | N_CHAINS | Per-chain flag, high for a cycle when that chain disagreed with the vote |
| upset_cnt_o | output | CNT_W | Saturating total of chain mismatches |
| error_o | output | 1 | Sticky indicator that an upset has been seen |

## Verification
The bench corrupts chain outputs and chain inputs by forcing nets, and tracks the chains with its own queues.

- **Fill window.** Outputs are corrupted while the chains are still filling. A design that opened its comparison early would flag or count there.
- **Vote thresholds.** Exactly half of the chains are inverted, and then one more than half. A vote with the wrong tie rule, or an off-by-one threshold, would flag the wrong group of chains.
- **Counter and error bit.** The counter is driven well past its top value to catch wraparound. A mismatch is raised on the same edge as a clear, which catches a counter that still counts on a clear edge.
- **Chain length.** A single corrupted input bit must reappear exactly one chain length later. A chain with the wrong number of stages, or with the bit lost, misses that cycle.

// File: rtl/seu_harness_pkg.sv
package seu_harness_pkg;
  localparam int unsigned DEF_CHAINS = 14;
  localparam int unsigned DEF_DEPTH  = 144;
  localparam int unsigned DEF_CNT_W  = 16;
endpackage

// File: rtl/seu_pattern_gen.sv
module seu_pattern_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pat_o
);
  logic pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pat_q <= 1'b0;
    else         pat_q <= ~pat_q;
  end

  assign pat_o = pat_q;
endmodule

// File: rtl/seu_shift_chain.sv
module seu_shift_chain #(
  parameter int unsigned DEPTH = 144
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic dout_o
);
  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[DEPTH-2:0], din_i};
  end

  assign dout_o = stage_q[DEPTH-1];
endmodule

// File: rtl/seu_vote_compare.sv
module seu_vote_compare #(
  parameter int unsigned N_CHAINS = 14,
  localparam int unsigned HIT_W   = $clog2(N_CHAINS + 1)
) (
  input  logic [N_CHAINS-1:0] bits_i,
  output logic [N_CHAINS-1:0] diff_o,
  output logic [HIT_W-1:0]    hits_o
);
  logic [HIT_W-1:0] ones;
  logic             vote;

  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(N_CHAINS); i++) ones = ones + HIT_W'(bits_i[i]);
  end

  // strict majority; an even split votes 0
  assign vote   = (ones > HIT_W'(N_CHAINS / 2));
  assign diff_o = bits_i ^ {N_CHAINS{vote}};

  always_comb begin
    hits_o = '0;
    for (int i = 0; i < int'(N_CHAINS); i++) hits_o = hits_o + HIT_W'(diff_o[i]);
  end
endmodule

// File: rtl/seu_upset_counter.sv
module seu_upset_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned HIT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             arm_i,
  input  logic [HIT_W-1:0] hits_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(hits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q <= (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
      if (hits_i != '0) err_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/seu_chain_harness.sv
module seu_chain_harness #(
  parameter int unsigned N_CHAINS = seu_harness_pkg::DEF_CHAINS,
  parameter int unsigned DEPTH    = seu_harness_pkg::DEF_DEPTH,
  parameter int unsigned CNT_W    = seu_harness_pkg::DEF_CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  output logic [N_CHAINS-1:0] mismatch_o,
  output logic [CNT_W-1:0]    upset_cnt_o,
  output logic                error_o
);
  localparam int unsigned HIT_W  = $clog2(N_CHAINS + 1);
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);

  logic                pat;
  logic [N_CHAINS-1:0] chain_out;
  logic [N_CHAINS-1:0] diff;
  logic [HIT_W-1:0]    hits;
  logic [HIT_W-1:0]    hits_armed;
  logic [FILL_W-1:0]   fill_q;
  logic                arm;
  logic [N_CHAINS-1:0] flag_q;

  seu_pattern_gen u_pat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pat_o  (pat)
  );

  for (genvar k = 0; k < int'(N_CHAINS); k++) begin : g_chain
    logic tap_in;
    logic tap_out;
    assign tap_in = pat;
    seu_shift_chain #(.DEPTH(DEPTH)) u_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (tap_in),
      .dout_o (tap_out)
    );
    assign chain_out[k] = tap_out;
  end

  // comparison held off until every stage holds post-reset data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fill_q <= '0;
    else if (!arm) fill_q <= fill_q + 1'b1;
  end
  assign arm = (fill_q == FILL_W'(DEPTH));

  seu_vote_compare #(.N_CHAINS(N_CHAINS)) u_vote (
    .bits_i (chain_out),
    .diff_o (diff),
    .hits_o (hits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flag_q <= '0;
    else if (arm) flag_q <= diff;
    else          flag_q <= '0;
  end

  assign hits_armed = arm ? hits : '0;

  seu_upset_counter #(.CNT_W(CNT_W), .HIT_W(HIT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .arm_i   (arm),
    .hits_i  (hits_armed),
    .cnt_o   (upset_cnt_o),
    .err_o   (error_o)
  );

  assign mismatch_o = flag_q;
endmodule

// File: rtl/seu_harness_checker.sv
module seu_harness_checker #(
  parameter int unsigned N_CHAINS = 14,
  parameter int unsigned DEPTH    = 144,
  parameter int unsigned CNT_W    = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clear_i,
  input logic [N_CHAINS-1:0] mismatch_o,
  input logic [CNT_W-1:0]    upset_cnt_o,
  input logic                error_o
);
  localparam int unsigned CYC_W = $clog2(DEPTH + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CYC_W-1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cyc_q <= '0;
    else if (cyc_q != CYC_W'(DEPTH + 1))  cyc_q <= cyc_q + 1'b1;
  end

  a_r3_fill_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q <= CYC_W'(DEPTH)) |-> (mismatch_o == '0));

  a_r4_minority_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mismatch_o) <= (N_CHAINS / 2));

  a_r6_count_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (upset_cnt_o >= $past(upset_cnt_o)));

  a_r7_saturate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && upset_cnt_o == CNT_TOP) |=> (upset_cnt_o == CNT_TOP));

  a_r8_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !clear_i) |=> error_o);

  a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((mismatch_o == '0) || error_o));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (upset_cnt_o == '0 && !error_o));
endmodule

bind seu_chain_harness seu_harness_checker #(
  .N_CHAINS (N_CHAINS),
  .DEPTH    (DEPTH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .mismatch_o  (mismatch_o),
  .upset_cnt_o (upset_cnt_o),
  .error_o     (error_o)
);

// File: tb/seu_chain_harness_tb.sv
module seu_chain_harness_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 14;
  localparam int DEPTH = 144;
  localparam int CNT_W = 16;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic [N-1:0]     mismatch_o;
  logic [CNT_W-1:0] upset_cnt_o;
  logic             error_o;

  seu_chain_harness #(.N_CHAINS(N), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i),
    .mismatch_o(mismatch_o), .upset_cnt_o(upset_cnt_o), .error_o(error_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  // stimulus requests for the next edge
  bit inv_out[N];
  bit inv_in[N];
  bit clr_req;
  // resolved force values
  bit fo_en[N], fo_val[N], fi_en[N], fi_val[N];
  event apply_ev;

  for (genvar k = 0; k < N; k++) begin : g_frc
    always @(apply_ev) begin
      if (fo_en[k]) begin
        if (fo_val[k]) force u_dut.g_chain[k].tap_out = 1'b1;
        else           force u_dut.g_chain[k].tap_out = 1'b0;
      end else release u_dut.g_chain[k].tap_out;
      if (fi_en[k]) begin
        if (fi_val[k]) force u_dut.g_chain[k].tap_in = 1'b1;
        else           force u_dut.g_chain[k].tap_in = 1'b0;
      end else release u_dut.g_chain[k].tap_in;
    end
  end

  // behavioural model
  bit ch[N][$];
  bit m_pat;
  int m_fill;
  int m_cnt;
  bit m_err;
  bit [N-1:0] m_flags;

  function automatic void model_reset();
    for (int k = 0; k < N; k++) begin
      ch[k].delete();
      for (int s = 0; s < DEPTH; s++) ch[k].push_back(1'b0);
    end
    m_pat = 0; m_fill = 0; m_cnt = 0; m_err = 0; m_flags = '0;
  endfunction

  function automatic void check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  task automatic compare();
    check(cur_req, "mismatch_o", int'(mismatch_o), int'(m_flags));
    check(cur_req, "upset_cnt_o", int'(upset_cnt_o), m_cnt);
    check(cur_req, "error_o", int'(error_o), int'(m_err));
  endtask

  // called at a negedge: drive next edge, model it, sample at next negedge
  task automatic tick();
    bit [N-1:0] outs;
    bit [N-1:0] diff;
    int ones, pc;
    bit vote;
    for (int k = 0; k < N; k++) begin
      outs[k]   = ch[k][DEPTH-1];
      fo_en[k]  = inv_out[k];
      fo_val[k] = ~outs[k];
      fi_en[k]  = inv_in[k];
      fi_val[k] = ~m_pat;
      if (inv_out[k]) outs[k] = ~outs[k];
    end
    -> apply_ev;
    clear_i = clr_req;
    ones = 0;
    for (int k = 0; k < N; k++) ones += int'(outs[k]);
    vote = (ones > N / 2);
    diff = outs ^ {N{vote}};
    pc = 0;
    for (int k = 0; k < N; k++) pc += int'(diff[k]);
    if (m_fill == DEPTH) m_flags = diff; else m_flags = '0;
    if (clr_req) begin
      m_cnt = 0; m_err = 0;
    end else if (m_fill == DEPTH) begin
      m_cnt = (m_cnt + pc > CMAX) ? CMAX : m_cnt + pc;
      if (pc > 0) m_err = 1;
    end
    for (int k = 0; k < N; k++) begin
      ch[k].push_front(inv_in[k] ? ~m_pat : m_pat);
      void'(ch[k].pop_back());
    end
    m_pat = ~m_pat;
    if (m_fill < DEPTH) m_fill++;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_req();
    for (int k = 0; k < N; k++) begin inv_out[k] = 0; inv_in[k] = 0; end
    clr_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_req();
    for (int k = 0; k < N; k++) begin fo_en[k] = 0; fi_en[k] = 0; end
    -> apply_ev;
    clear_i = 0;
    rst_ni = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    cur_req = "R1";
    compare();
    rst_ni = 1;
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    clear_req();
    do_reset();

    // R3: disagreement during fill is masked
    cur_req = "R3";
    idle(10);
    inv_out[5] = 1; idle(3); inv_out[5] = 0;
    inv_out[0] = 1; inv_out[1] = 1; inv_out[2] = 1; idle(1); clear_req();
    idle(DEPTH - 14);
    check("R3", "count after fill window", int'(upset_cnt_o), 0);

    // R2: clean running
    cur_req = "R2";
    idle(40);
    check("R2", "clean error_o", int'(error_o), 0);

    // R4: single chain output disagrees for one cycle
    cur_req = "R4";
    inv_out[2] = 1; tick(); clear_req();
    check("R4", "flag bit 2", int'(mismatch_o), 1 << 2);
    tick();
    check("R4", "flag cleared next cycle", int'(mismatch_o), 0);
    idle(3);

    // R6: several chains at once
    cur_req = "R6";
    inv_out[4] = 1; inv_out[11] = 1; inv_out[13] = 1; tick(); clear_req();
    check("R6", "count after 1+3", int'(upset_cnt_o), 4);
    idle(2);

    // R8: sticky stays through quiet cycles
    cur_req = "R8";
    idle(20);
    check("R8", "error_o held", int'(error_o), 1);

    // R9: clear with concurrent mismatch
    cur_req = "R9";
    clr_req = 1; inv_out[7] = 1; tick(); clear_req();
    check("R9", "flag still reported", int'(mismatch_o), 1 << 7);
    check("R9", "count cleared", int'(upset_cnt_o), 0);
    check("R9", "error cleared", int'(error_o), 0);
    idle(2);

    // R5: even split and one over half
    cur_req = "R5";
    for (int k = 0; k < 7; k++) inv_out[k] = 1;
    tick(); tick(); clear_req();
    for (int k = 0; k < 8; k++) inv_out[k] = 1;
    tick(); clear_req();
    check("R5", "8 inverted -> 6 flagged", $countones(mismatch_o), 6);
    idle(2);

    // R10: corrupted input reappears DEPTH edges later
    cur_req = "R10";
    clr_req = 1; tick(); clear_req();
    inv_in[9] = 1; tick(); clear_req();
    idle(DEPTH - 1);
    check("R10", "not yet visible", int'(mismatch_o), 0);
    tick();
    check("R10", "flag at DEPTH", int'(mismatch_o), 1 << 9);
    tick();
    check("R10", "single cycle", int'(mismatch_o), 0);
    inv_in[1] = 1; inv_in[12] = 1; tick(); clear_req();
    idle(DEPTH + 2);
    check("R10", "two-chain count", int'(upset_cnt_o), 3);

    // R7: saturation
    cur_req = "R7";
    for (int k = 0; k < 7; k++) inv_out[k] = 1;
    idle(9400); clear_req();
    check("R7", "saturated", int'(upset_cnt_o), CMAX);
    inv_out[3] = 1; idle(3); clear_req();
    check("R7", "held at top", int'(upset_cnt_o), CMAX);
    clr_req = 1; tick(); clear_req();
    check("R9", "clear from top", int'(upset_cnt_o), 0);

    // R1/R3: reset mid-run then mask again
    do_reset();
    check("R1", "count after reset", int'(upset_cnt_o), 0);
    cur_req = "R3";
    inv_out[6] = 1; idle(DEPTH); clear_req();
    check("R3", "masked after re-reset", int'(error_o), 0);
    inv_out[6] = 1; tick(); clear_req();
    check("R4", "first armed edge flags", int'(mismatch_o), 1 << 6);
    idle(5);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule